// File: doc/BRIEF.md
# Serial Byte Master with Chip-Select Contention Guard

This block is a synchronous serial master that moves one byte per transfer. Software writes a control word that holds a master-enable bit, a two-bit chip-select mode and an interface-mode bit. A write to the transmit strobe then shifts the byte out MSB first and shifts a byte in at the same time. The serial clock is the system clock divided by a fixed parameter. It idles high. Data changes on the falling edge and is captured on the rising edge.

When the chip-select mode is `2'b10` and the interface-mode bit is 0, the block shares its chip-select line with other masters. It releases the pin whenever it is not moving data. During two windows it watches the pin through a two-flop synchronizer. The first window is the idle time while master mode is enabled. The second is a short tail after each byte. A low level seen in either window means another master holds the bus. The block then raises a sticky conflict flag, drops its own master-enable bit, and refuses to start new transfers until software writes the flag back to 0.

Top module: `spi_guard_master`

## Requirements
- R1: After synchronous reset, master_en, conflict and busy are 0. sck is 1 and the stored chip-select mode is `2'b00`, so cs_oe is 1 and cs_out is 1.
- R2: A cycle with ctl_wr high loads ctl_en, ctl_cs_mode and ctl_if_mode into the control word. The master_en output shows the stored enable bit from the next cycle on.
- R3: A tx_wr pulse starts a transfer only when the block is idle, master_en is 1 and conflict is 0. Any other tx_wr pulse is ignored: busy stays 0 and sck stays high.
- R4: A transfer shifts the byte out MSB first. mosi updates on each falling sck edge and miso is captured on each rising edge. The sck period is CLK_DIV system clocks and sck idles high. After the transfer, rx_data holds the byte received.
- R5: During a transfer, cs_oe is 1 and cs_out is 0. Outside a transfer, the pin is released (cs_oe = 0) in the guarded configuration (chip-select mode `2'b10`, interface-mode 0). In every other configuration, cs_oe is 1 and cs_out is 1 outside a transfer.
- R6: In the guarded configuration, while idle with master_en at 1, a synchronized low on cs_in sets conflict to 1 and clears master_en.
- R7: busy stays high for 16·(CLK_DIV/2) + 2 + TAIL_WIN cycles per transfer. It covers a tail that follows the last rising sck edge. In that tail, after two settling cycles, a synchronized low on cs_in sets conflict and clears master_en.
- R8: cs_in is not checked for conflicts during a transfer, nor in any configuration other than the guarded one.
- R9: While conflict is 1, tx_wr starts nothing, even after master_en has been written back to 1.
- R10: conflict is cleared only by a stat_wr cycle with stat_flag_wdata = 0. A stat_wr cycle with a 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_en | input | 1 | Master-enable value to write |
| ctl_cs_mode | input | 2 | Chip-select mode value to write (`2'b10` selects guarding) |
| ctl_if_mode | input | 1 | Interface-mode value to write (0 needed for guarding) |
| stat_wr | input | 1 | Status write strobe |
| stat_flag_wdata | input | 1 | Value written to the conflict flag (only 0 acts) |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | DATA_W | Byte to transmit |
| master_en | output | 1 | Current master-enable bit |
| conflict | output | 1 | Sticky conflict flag |
| busy | output | 1 | Transfer or post-transfer window in progress |
| rx_data | output | DATA_W | Last byte received |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip-select drive value |
| cs_oe | output | 1 | Chip-select output enable |
| cs_in | input | 1 | Chip-select pin sense |

## Verification
The bench builds the block with CLK_DIV = 4 and TAIL_WIN = 4. Each byte therefore takes 32 cycles and the whole busy span is 38 cycles. That is short enough to run many random byte pairs and still land contention pulses exactly before, inside and after a transfer. With the short tail, a pin held low from mid-transfer onward is the case that trips the tail window. A pulse that ends before the last sck edge must not trip it.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic       master_en;
        logic [1:0] cs_mode;
        logic       if_mode;
    } ctl_reg_t;

    localparam logic [1:0] CS_MODE_GUARD = 2'b10;

    // Contention guarding applies only in this configuration.
    function automatic logic guard_cfg(input ctl_reg_t c);
        return (c.cs_mode == CS_MODE_GUARD) && !c.if_mode;
    endfunction

endpackage

// File: rtl/spi_guard_sync.sv
module spi_guard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_guard_shifter.sv
module spi_guard_shifter #(
    parameter int DATA_W = 8,
    parameter int HALF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              active,
    output logic              last_edge,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(DATA_W);

    logic [HC_W-1:0]   hc;
    logic [BIT_W-1:0]  bits;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              tick;

    assign tick      = active && (hc == HC_W'(HALF - 1));
    assign last_edge = tick && !sck && (bits == BIT_W'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sck     <= 1'b1;
            mosi    <= 1'b0;
            hc      <= '0;
            bits    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                tx_sh  <= tx_byte;
                hc     <= '0;
                bits   <= '0;
            end
        end else begin
            hc <= tick ? '0 : hc + 1'b1;
            if (tick && sck) begin
                sck   <= 1'b0;
                mosi  <= tx_sh[DATA_W-1];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (tick && !sck) begin
                sck   <= 1'b1;
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
                bits  <= bits + 1'b1;
                if (last_edge) begin
                    active  <= 1'b0;
                    rx_byte <= {rx_sh[DATA_W-2:0], miso};
                end
            end
        end
    end
endmodule

// File: rtl/spi_guard_ctrl.sv
module spi_guard_ctrl
    import spi_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TAIL_WIN    = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_wr,
    input  ctl_reg_t ctl_wdata,
    input  logic     stat_wr,
    input  logic     stat_wdata,
    input  logic     tx_wr,
    input  logic     cs_sync,
    input  logic     last_edge,
    output ctl_reg_t ctl,
    output logic     conflict,
    output logic     busy,
    output logic     start,
    output logic     cs_oe,
    output logic     cs_out
);
    localparam int TAIL_LEN = SYNC_STAGES + TAIL_WIN;
    localparam int TC_W     = $clog2(TAIL_LEN + 1);

    xfer_state_e     state;
    logic [TC_W-1:0] tc;
    logic            guard, pre_win, post_win, hit;

    assign guard    = guard_cfg(ctl);
    assign pre_win  = guard && ctl.master_en && (state == ST_IDLE);
    assign post_win = guard && (state == ST_TAIL) && (tc >= TC_W'(SYNC_STAGES));
    assign hit      = (pre_win || post_win) && !cs_sync;
    assign start    = tx_wr && ctl.master_en && !conflict && !hit && (state == ST_IDLE);

    assign busy   = (state != ST_IDLE);
    assign cs_oe  = !guard || (state == ST_XFER);
    assign cs_out = (state != ST_XFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            conflict <= 1'b0;
            state    <= ST_IDLE;
            tc       <= '0;
        end else begin
            if (ctl_wr) ctl <= ctl_wdata;
            if (hit) begin
                conflict      <= 1'b1;
                ctl.master_en <= 1'b0;
            end else if (stat_wr && !stat_wdata) begin
                conflict <= 1'b0;
            end
            unique case (state)
                ST_IDLE: if (start) state <= ST_XFER;
                ST_XFER: if (last_edge) begin
                    state <= ST_TAIL;
                    tc    <= '0;
                end
                ST_TAIL: begin
                    if (tc == TC_W'(TAIL_LEN - 1)) state <= ST_IDLE;
                    else                            tc    <= tc + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6 / R7: a hit in either window raises the flag and drops master mode
    a_r6_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        hit |=> conflict && !ctl.master_en);

    // R9: nothing starts while the flag stands
    a_r9_no_start_flagged: assert property (@(posedge clk) disable iff (rst)
        conflict |-> !start);

    // R10: flag only falls on a write of zero
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        conflict && !(stat_wr && !stat_wdata) |=> conflict);
endmodule

// File: rtl/spi_guard_master.sv
module spi_guard_master
    import spi_guard_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CLK_DIV     = 4,
    parameter int TAIL_WIN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic [1:0]        ctl_cs_mode,
    input  logic              ctl_if_mode,
    input  logic              stat_wr,
    input  logic              stat_flag_wdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              master_en,
    output logic              conflict,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_out,
    output logic              cs_oe,
    input  logic              cs_in
);
    localparam int HALF = CLK_DIV / 2;

    ctl_reg_t ctl_wdata, ctl_q;
    logic     cs_sync, start, last_edge, sh_active;

    assign ctl_wdata = '{master_en: ctl_en, cs_mode: ctl_cs_mode, if_mode: ctl_if_mode};
    assign master_en = ctl_q.master_en;

    spi_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(cs_in), .q(cs_sync)
    );

    spi_guard_shifter #(.DATA_W(DATA_W), .HALF(HALF)) u_shift (
        .clk(clk), .rst(rst), .start(start), .tx_byte(tx_data), .miso(miso),
        .sck(sck), .mosi(mosi), .active(sh_active), .last_edge(last_edge),
        .rx_byte(rx_data)
    );

    spi_guard_ctrl #(.SYNC_STAGES(SYNC_STAGES), .TAIL_WIN(TAIL_WIN)) u_ctrl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_flag_wdata), .tx_wr(tx_wr),
        .cs_sync(cs_sync), .last_edge(last_edge), .ctl(ctl_q),
        .conflict(conflict), .busy(busy), .start(start),
        .cs_oe(cs_oe), .cs_out(cs_out)
    );

    // R5: the shifter never runs unless chip-select is driven low
    a_r5_drive_low_xfer: assert property (@(posedge clk) disable iff (rst)
        sh_active |-> cs_oe && !cs_out);

    // R5 / R8: guarded and idle means the pin is released
    a_r5_release_idle: assert property (@(posedge clk) disable iff (rst)
        !busy && guard_cfg(ctl_q) |-> !cs_oe);

    // R4: sck parks high whenever no byte is moving
    a_r4_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
        !sh_active |-> sck);
endmodule

// File: tb/spi_guard_master_bench.sv
module spi_guard_master_bench;
    localparam int DW   = 8;
    localparam int DIV  = 4;
    localparam int TAIL = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic ctl_wr = 0, ctl_en = 0, ctl_if_mode = 0, stat_wr = 0, stat_flag_wdata = 0, tx_wr = 0;
    logic [1:0] ctl_cs_mode = 2'b00;
    logic [DW-1:0] tx_data = '0, rx_data, slave_byte = '0, cap = '0;
    logic master_en, conflict, busy, sck, mosi, miso, cs_out, cs_oe, cs_in;
    logic ext_low = 1'b0;
    logic [2:0] fall_idx = 3'd0;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    // Shared pin: low if this block drives low or another master pulls it
    assign cs_in = !(ext_low || (cs_oe && !cs_out));
    assign miso  = slave_byte[3'(3'd0 - fall_idx)];
    always @(negedge sck) fall_idx <= fall_idx + 3'd1;
    always @(posedge sck) cap <= {cap[DW-2:0], mosi};

    spi_guard_master #(.DATA_W(DW), .CLK_DIV(DIV), .TAIL_WIN(TAIL)) u_spi_guard_master (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_cs_mode(ctl_cs_mode),
        .ctl_if_mode(ctl_if_mode), .stat_wr(stat_wr), .stat_flag_wdata(stat_flag_wdata),
        .tx_wr(tx_wr), .tx_data(tx_data), .master_en(master_en), .conflict(conflict),
        .busy(busy), .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_out(cs_out), .cs_oe(cs_oe), .cs_in(cs_in)
    );

    function automatic int exp_busy_cycles(input int div, input int tail);
        return 16 * (div / 2) + 2 + tail;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic en, input logic [1:0] mode, input logic ifm);
        @(negedge clk);
        ctl_wr = 1; ctl_en = en; ctl_cs_mode = mode; ctl_if_mode = ifm;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic write_flag(input logic v);
        @(negedge clk);
        stat_wr = 1; stat_flag_wdata = v;
        @(negedge clk);
        stat_wr = 0;
    endtask

    // Runs one byte; pull_on/pull_off pick busy-cycle indices for ext_low (0 = none)
    task automatic xfer(input logic [DW-1:0] tx, input logic [DW-1:0] sl,
                        input int pull_on, input int pull_off, input logic guarded);
        int n = 0;
        @(negedge clk);
        slave_byte = sl; tx_data = tx; tx_wr = 1;
        @(negedge clk);
        tx_wr = 0;
        while (busy && n < 1000) begin
            n++;
            if (n == pull_on)  ext_low = 1;
            if (n == pull_off) ext_low = 0;
            if (n == 10) begin
                chk("R5 cs_oe in xfer", 32'(cs_oe), 1);
                chk("R5 cs_out in xfer", 32'(cs_out), 0);
            end
            @(negedge clk);
        end
        chk("R7 busy span", n, exp_busy_cycles(DIV, TAIL));
        chk("R4 mosi byte", 32'(cap), 32'(tx));
        chk("R4 rx byte", 32'(rx_data), 32'(sl));
        chk("R4 sck idle", 32'(sck), 1);
        if (!guarded) chk("R5 oe idle unguarded", 32'(cs_oe), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 master_en", 32'(master_en), 0);
        chk("R1 conflict", 32'(conflict), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 sck", 32'(sck), 1);
        chk("R1 cs_oe", 32'(cs_oe), 1);
        chk("R1 cs_out", 32'(cs_out), 1);

        // R3: write while disabled is ignored
        @(negedge clk); tx_wr = 1; tx_data = 8'hA5;
        @(negedge clk); tx_wr = 0;
        repeat (3) @(negedge clk);
        chk("R3 ignored when disabled", 32'(busy), 0);

        // R2 / R5
        set_ctl(1, 2'b10, 0);
        chk("R2 master_en readback", 32'(master_en), 1);
        chk("R5 released in guard idle", 32'(cs_oe), 0);

        for (int i = 0; i < 8; i++) begin
            xfer(8'($urandom), 8'($urandom), 0, 0, 1);
            chk("R6 no false conflict", 32'(conflict), 0);
        end
        xfer(8'h80, 8'h01, 0, 0, 1);
        xfer(8'hFF, 8'h00, 0, 0, 1);

        // R8: low pulse entirely inside the transfer is not sampled
        xfer(8'h3C, 8'hC3, 5, 25, 1);
        repeat (4) @(negedge clk);
        chk("R8 no conflict mid-xfer", 32'(conflict), 0);

        // R8: other configurations ignore the pin
        set_ctl(1, 2'b11, 0);
        ext_low = 1;
        repeat (6) @(negedge clk);
        chk("R8 mode 11 ignores pin", 32'(conflict), 0);
        chk("R5 mode 11 drives high", 32'(cs_oe & cs_out), 1);
        xfer(8'h5A, 8'h96, 0, 0, 0);
        set_ctl(1, 2'b10, 1);
        repeat (6) @(negedge clk);
        chk("R8 if_mode 1 ignores pin", 32'(conflict), 0);
        ext_low = 0;

        // R6: pre-transfer window
        set_ctl(1, 2'b10, 0);
        repeat (3) @(negedge clk);
        ext_low = 1;
        repeat (4) @(negedge clk);
        ext_low = 0;
        chk("R6 conflict set", 32'(conflict), 1);
        chk("R6 master_en cleared", 32'(master_en), 0);

        // R9: blocked while flagged, even with master_en rewritten
        set_ctl(1, 2'b10, 0);
        @(negedge clk); tx_wr = 1; tx_data = 8'h11;
        @(negedge clk); tx_wr = 0;
        repeat (4) @(negedge clk);
        chk("R9 blocked busy", 32'(busy), 0);
        chk("R9 blocked sck", 32'(sck), 1);

        // R10
        write_flag(1);
        chk("R10 write one keeps flag", 32'(conflict), 1);
        write_flag(0);
        chk("R10 write zero clears", 32'(conflict), 0);

        // R9: resumes after clear
        xfer(8'hC7, 8'h7C, 0, 0, 1);
        chk("R9 resumed no conflict", 32'(conflict), 0);

        // R7: tail window catches a pin held low past transfer end
        xfer(8'h42, 8'h24, 5, 0, 1);
        chk("R7 tail conflict", 32'(conflict), 1);
        chk("R7 tail drops master_en", 32'(master_en), 0);
        ext_low = 0;
        write_flag(0);
        set_ctl(1, 2'b10, 0);
        for (int i = 0; i < 4; i++) xfer(8'($urandom), 8'($urandom), 0, 0, 1);
        chk("R9 clean after recovery", 32'(conflict), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule